// File: doc/BRIEF.md
# Dual-Hit Pixel Time Stamp Capture

This block is the digital front end that sits behind one pixel of a binary hit-detecting sensor matrix. A shared counter drives a narrow time stamp bus to every pixel. The block watches the discriminator output of its own pixel and can hold up to `NUM_SLOTS` hits, two by default, in each acquisition window. Every hit it keeps gets its own frozen copy of the bus value from the moment it was captured. A per-pixel kill mask can switch the pixel off completely.

Operation alternates between two phases, chosen by `phase_det`. In the detection phase, which matches the bunch train, rising edges of the synchronized discriminator fill the slots in index order. A hit that arrives when every slot is already full is dropped, and the overflow flag is set.

In the readout phase, which matches the gap between trains, the stored hits leave through a valid/ready stream, lowest slot first. Back-pressure follows the usual rules:
- `rd_valid` stays high while any slot is pending.
- `rd_ts` and `rd_slot` hold still for as long as `rd_ready` is low.
- Each cycle with both `rd_valid` and `rd_ready` high releases the slot on offer.

A `win_start` pulse at the start of each window empties all slots and clears the overflow flag. It leaves the mask alone.

Top module: `pixel_hit_stamper`

## Requirements
- R1: The first accepted hit in a window sets pending bit 0 (`pend[0]`). Stamp field 0 (`stamp_q[TS_W-1:0]`) freezes at the `ts_bus` value present in the cycle before the edge that sets the flag, and stays unchanged while the slot is pending.
- R2: A hit accepted while slot 0 is pending sets pending bit 1 and freezes stamp field 1 (`stamp_q[2*TS_W-1:TS_W]`) in the same way. Slot 0 is left untouched.
- R3: A hit that arrives in the detection phase while all slots are pending is dropped. The overflow flag rises, and no stamp or pending bit changes.
- R4: `disc_in` passes through a two-flop synchronizer. A hit is counted only on a rising edge: the pending flag appears at the second clock edge after the edge that first samples `disc_in` high. A level held high over many cycles counts as one hit.
- R5: Rising edges that occur while `phase_det` is 0 (readout phase) are ignored and are not recorded later.
- R6: `mask_wr` loads `mask_din` into the kill mask, shown on `mask_q`. While the mask is 1, no hit sets any pending bit.
- R7: `rd_valid` is high only when `phase_det` is 0 and at least one slot is pending. `rd_slot` and `rd_ts` give the lowest pending slot and its stamp, and they stay stable while `rd_ready` is low. A handshake clears that slot.
- R8: A slot that is not pending follows the bus: its stamp field equals the `ts_bus` value of the previous cycle. This includes a slot that has just been released.
- R9: `win_start` clears all pending bits and the overflow flag at the next edge, takes priority over a hit in the same cycle, and leaves `mask_q` unchanged.
- R10: After reset, the pending bits, the overflow flag, `rd_valid` and the mask are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_det | input | 1 | 1 = detection phase, 0 = readout phase |
| win_start | input | 1 | Start-of-window pulse; empties the slots and clears overflow |
| mask_wr | input | 1 | Load strobe for the kill mask |
| mask_din | input | 1 | New kill mask value |
| disc_in | input | 1 | Asynchronous discriminator output |
| ts_bus | input | TS_W | Shared time stamp bus |
| rd_ready | input | 1 | Readout sink ready |
| rd_valid | output | 1 | A stored hit is on offer |
| rd_slot | output | SLOT_W | Index of the slot on offer |
| rd_ts | output | TS_W | Stamp of the slot on offer |
| pend | output | NUM_SLOTS | Pending flag for each slot |
| stamp_q | output | NUM_SLOTS*TS_W | Stamp fields, slot i at bits [i*TS_W +: TS_W] |
| overflow | output | 1 | A hit was dropped in this window |
| mask_q | output | 1 | Current kill mask |

## Verification
The bench builds the block with its defaults: a 5-bit stamp and two slots. With two slots, the third hit in a window reaches the full condition, so the drop-and-overflow path gets exercised. A 5-bit bus is small enough to choose stamp values that are easy to tell apart and that cover the top code. The stream side is tested with `rd_ready` held low for several cycles and then high for back-to-back pops, and a scoreboard matches every popped stamp against the order in which hits were driven.

// File: rtl/pixfe_pkg.sv
package pixfe_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_STORE = 2'd1,
    EV_DROP  = 2'd2
  } hit_event_e;
endpackage

// File: rtl/hit_edge_sync.sv
module hit_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/stamp_slot.sv
module stamp_slot #(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            rel,
  input  logic            flush,
  input  logic [TS_W-1:0] ts_bus,
  output logic            pend,
  output logic [TS_W-1:0] stamp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (flush) begin
      pend <= 1'b0;
    end else if (capture) begin
      pend <= 1'b1;
    end else if (rel) begin
      pend <= 1'b0;
    end
  end

  // A free slot tracks the bus; the edge that sets pend loads the last value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp <= '0;
    end else if (!pend) begin
      stamp <= ts_bus;
    end
  end
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl #(
  parameter int NUM_SLOTS = 2,
  parameter int SLOT_W    = 1
) (
  input  logic                 accept,
  input  logic                 pop,
  input  logic [NUM_SLOTS-1:0] pend,
  output logic [NUM_SLOTS-1:0] capture,
  output logic [NUM_SLOTS-1:0] rel,
  output logic [SLOT_W-1:0]    sel,
  output logic                 full
);
  logic found_free;
  logic found_busy;

  always_comb begin
    capture    = '0;
    rel        = '0;
    sel        = '0;
    found_free = 1'b0;
    found_busy = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!pend[i] && !found_free) begin
        found_free = 1'b1;
        capture[i] = accept;
      end
      if (pend[i] && !found_busy) begin
        found_busy = 1'b1;
        rel[i]     = pop;
        sel        = SLOT_W'(i);
      end
    end
    full = ~found_free;
  end
endmodule

// File: rtl/pixel_hit_stamper.sv
module pixel_hit_stamper
  import pixfe_pkg::*;
#(
  parameter int TS_W      = 5,
  parameter int NUM_SLOTS = 2,
  parameter int SYNC_STG  = 2,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      phase_det,
  input  logic                      win_start,
  input  logic                      mask_wr,
  input  logic                      mask_din,
  input  logic                      disc_in,
  input  logic [TS_W-1:0]           ts_bus,
  input  logic                      rd_ready,
  output logic                      rd_valid,
  output logic [SLOT_W-1:0]         rd_slot,
  output logic [TS_W-1:0]           rd_ts,
  output logic [NUM_SLOTS-1:0]      pend,
  output logic [NUM_SLOTS*TS_W-1:0] stamp_q,
  output logic                      overflow,
  output logic                      mask_q
);
  logic                 rise;
  logic                 accept;
  logic                 pop;
  logic                 full;
  logic [NUM_SLOTS-1:0] capture;
  logic [NUM_SLOTS-1:0] rel;
  logic [TS_W-1:0]      stamps [NUM_SLOTS];
  hit_event_e           ev;

  hit_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (disc_in),
    .rise (rise)
  );

  assign accept   = rise & phase_det & ~mask_q & ~win_start;
  assign rd_valid = ~phase_det & (|pend);
  assign pop      = rd_valid & rd_ready;

  slot_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .accept (accept),
    .pop    (pop),
    .pend   (pend),
    .capture(capture),
    .rel    (rel),
    .sel    (rd_slot),
    .full   (full)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    stamp_slot #(.TS_W(TS_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(capture[g]),
      .rel    (rel[g]),
      .flush  (win_start),
      .ts_bus (ts_bus),
      .pend   (pend[g]),
      .stamp  (stamps[g])
    );
    assign stamp_q[g*TS_W +: TS_W] = stamps[g];
  end

  assign rd_ts = stamps[rd_slot];

  always_comb begin
    if (!accept)   ev = EV_NONE;
    else if (full) ev = EV_DROP;
    else           ev = EV_STORE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow <= 1'b0;
    end else if (win_start) begin
      overflow <= 1'b0;
    end else if (ev == EV_DROP) begin
      overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
    end else if (mask_wr) begin
      mask_q <= mask_din;
    end
  end
endmodule

// File: rtl/pixel_hit_stamper_chk.sv
module pixel_hit_stamper_chk #(
  parameter int TS_W      = 5,
  parameter int NUM_SLOTS = 2,
  parameter int SLOT_W    = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      phase_det,
  input logic                      win_start,
  input logic                      rd_ready,
  input logic                      rd_valid,
  input logic [SLOT_W-1:0]         rd_slot,
  input logic [TS_W-1:0]           rd_ts,
  input logic [NUM_SLOTS-1:0]      pend,
  input logic [NUM_SLOTS*TS_W-1:0] stamp_q,
  input logic                      overflow,
  input logic                      mask_q
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hold
    AST_STAMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && $past(pend[g])) |-> (stamp_q[g*TS_W +: TS_W] == $past(stamp_q[g*TS_W +: TS_W]))); // R1
  end

  AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(&pend)); // R3

  AST_NO_CAPTURE_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!phase_det) |-> ((pend & ~$past(pend)) == '0)); // R5

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_q) |-> ((pend & ~$past(pend)) == '0)); // R6

  AST_VALID_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!phase_det && (pend != '0))); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !win_start) |=>
      (phase_det || (rd_valid && $stable(rd_ts) && $stable(rd_slot)))); // R7

  AST_WIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> ((pend == '0) && !overflow)); // R9
endmodule

bind pixel_hit_stamper pixel_hit_stamper_chk #(
  .TS_W(TS_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_det(phase_det), .win_start(win_start),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_slot(rd_slot), .rd_ts(rd_ts),
  .pend(pend), .stamp_q(stamp_q), .overflow(overflow), .mask_q(mask_q)
);

// File: tb/pixel_hit_stamper_tb.sv
module pixel_hit_stamper_tb;
  localparam int CLK_P = 10;
  localparam int TS_W  = 5;
  localparam int NS    = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            phase_det = 1'b0;
  logic            win_start = 1'b0;
  logic            mask_wr = 1'b0;
  logic            mask_din = 1'b0;
  logic            disc_in = 1'b0;
  logic [TS_W-1:0] ts_bus = '0;
  logic            rd_ready = 1'b0;
  logic            rd_valid;
  logic [0:0]      rd_slot;
  logic [TS_W-1:0] rd_ts;
  logic [NS-1:0]   pend;
  logic [NS*TS_W-1:0] stamp_q;
  logic            overflow;
  logic            mask_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  pixel_hit_stamper u_dut (
    .clk(clk), .rst_n(rst_n), .phase_det(phase_det), .win_start(win_start),
    .mask_wr(mask_wr), .mask_din(mask_din), .disc_in(disc_in), .ts_bus(ts_bus),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_slot(rd_slot), .rd_ts(rd_ts),
    .pend(pend), .stamp_q(stamp_q), .overflow(overflow), .mask_q(mask_q)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one discriminator pulse with the bus held; optionally expects a store.
  task automatic drive_hit(int ts, bit expect_store, int slot);
    ts_bus  = TS_W'(ts);
    disc_in = 1'b1;
    tick(6);
    disc_in = 1'b0;
    tick(3);
    if (expect_store) exp_q.push_back((slot << 8) | ts);
  endtask

  task automatic pulse_win();
    win_start = 1'b1;
    tick(1);
    win_start = 1'b0;
  endtask

  task automatic write_mask(bit v);
    mask_din = v;
    mask_wr  = 1'b1;
    tick(1);
    mask_wr  = 1'b0;
  endtask

  // Scoreboard monitor: compares each handshake against the expected order (R7)
  always @(posedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected pop", 1, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        check("R7 popped slot", int'(rd_slot), e >> 8);
        check("R7 popped stamp", int'(rd_ts), e & 8'hff);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R10 reset state
    check("R10 pend", int'(pend), 0);
    check("R10 overflow", int'(overflow), 0);
    check("R10 rd_valid", int'(rd_valid), 0);
    check("R10 mask", int'(mask_q), 0);

    phase_det = 1'b1;
    pulse_win();

    // R4 latency and R1 first hit
    ts_bus  = 5'd5;
    disc_in = 1'b1;
    tick(2);
    check("R4 no flag before sync", int'(pend), 0);
    tick(1);
    check("R4 flag after sync", int'(pend), 1);
    check("R1 stamp0", int'(stamp_q[4:0]), 5);
    tick(5);
    check("R4 held level counts once", int'(pend), 1);
    disc_in = 1'b0;
    tick(3);
    exp_q.push_back(5);

    // R8 free slot follows, R1 held slot frozen
    ts_bus = 5'd9;
    tick(1);
    check("R8 stamp1 follows bus", int'(stamp_q[9:5]), 9);
    check("R1 stamp0 frozen", int'(stamp_q[4:0]), 5);

    // R2 second hit
    drive_hit(17, 1'b1, 1);
    check("R2 pend both", int'(pend), 3);
    check("R2 stamp1", int'(stamp_q[9:5]), 17);
    check("R2 stamp0 untouched", int'(stamp_q[4:0]), 5);
    check("R3 no overflow yet", int'(overflow), 0);

    // R3 third hit dropped
    drive_hit(3, 1'b0, 0);
    check("R3 overflow", int'(overflow), 1);
    check("R3 stamp0 kept", int'(stamp_q[4:0]), 5);
    check("R3 stamp1 kept", int'(stamp_q[9:5]), 17);

    // R7 back-pressure
    phase_det = 1'b0;
    tick(1);
    check("R7 valid", int'(rd_valid), 1);
    check("R7 slot", int'(rd_slot), 0);
    check("R7 stamp", int'(rd_ts), 5);
    tick(3);
    check("R7 held slot", int'(rd_slot), 0);
    check("R7 held stamp", int'(rd_ts), 5);
    rd_ready = 1'b1;
    tick(3);
    rd_ready = 1'b0;
    check("R7 drained", int'(rd_valid), 0);
    check("R7 pend empty", int'(pend), 0);
    check("R7 scoreboard empty", exp_q.size(), 0);
    check("R9 overflow kept until window", int'(overflow), 1);
    ts_bus = 5'd22;
    tick(1);
    check("R8 released slot follows", int'(stamp_q[4:0]), 22);

    // R5 readout hit ignored, not recorded later
    drive_hit(12, 1'b0, 0);
    check("R5 readout hit", int'(pend), 0);
    phase_det = 1'b1;
    tick(2);
    check("R5 not recorded later", int'(pend), 0);

    // R9 window start with mask set, R6 mask blocks
    write_mask(1'b1);
    check("R6 mask loaded", int'(mask_q), 1);
    pulse_win();
    check("R9 overflow cleared", int'(overflow), 0);
    check("R9 mask kept", int'(mask_q), 1);
    drive_hit(7, 1'b0, 0);
    check("R6 masked hit", int'(pend), 0);
    write_mask(1'b0);
    drive_hit(31, 1'b1, 0);
    check("R6 unmasked hit", int'(pend), 1);
    check("R6 stamp top code", int'(stamp_q[4:0]), 31);

    // R9 window start clears pending
    drive_hit(2, 1'b0, 0);
    check("R9 pend full before", int'(pend), 3);
    exp_q.delete();
    pulse_win();
    check("R9 pend cleared", int'(pend), 0);

    // R7 final scoreboard pass
    drive_hit(14, 1'b1, 0);
    phase_det = 1'b0;
    rd_ready  = 1'b1;
    tick(3);
    rd_ready  = 1'b0;
    check("R7 final drain", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule